// File: doc/BRIEF.md
# Complementary Dead-Time PWM Controller

This block drives the two switches of a half-bridge with a pair of complementary pulse-width modulated signals that are never active together. A free-running counter is compared with a pulse-width value held in a compare latch. The primary output follows the compare result. The secondary output follows its inverse. Each time the compare result changes, both outputs are held low for a programmable number of counter ticks, so that one switch is off before the other turns on.

A simple write port loads two registers. One is a pulse-width holding register. The other is a control register that holds the clock prescale, the counter width (8 or 7 bits), the dead-time length, a stop bit and a lock bit. A new pulse width reaches the compare latch only at a period boundary. After the lock bit is set, only the stop bit can still be written, and only reset clears the lock.

Top module: `dtpwm_ctrl`

## Requirements
- R1: After reset the controller runs in 8-bit mode with no prescale, zero dead time, stop and lock clear and a pulse width of 0. With these settings the primary output `out_a` is low and the secondary output `out_b` is high.
- R2: `out_a` and `out_b` are never both high.
- R3: The control field bits 7:4 hold the dead time D, counted in counter ticks. After every change of the compare result, both outputs stay low for D ticks. When D = 0 there is no blanking. In 8-bit mode with no prescale, a pulse width of 128 and D = 3, `out_a` is high for 125 of every 256 clocks.
- R4: Control bit 1 is the lock. Once it is set, a control write updates only the stop bit (bit 0). Dead time, prescale, width and the lock bit keep their values until reset.
- R5: Control bit 3 selects 7-bit mode. The counter counts 0..127 in 7-bit mode and 0..255 in 8-bit mode, so the period is 128 or 256 ticks.
- R6: Control bit 2 selects the prescale. When it is set, the counter advances once every two clocks, and the period doubles in clocks.
- R7: A write with `wr_sel` = 0 loads the pulse-width holding register. Its value is moved into the compare latch only when the counter wraps or while the block is stopped, so the current period completes with the old value.
- R8: While control bit 0 (stop) is set, both outputs are low and the counter is held at zero. Clearing the bit restarts the count from zero.
- R9: The compare result is high while the count is less than the pulse width. In 7-bit mode, a pulse width of 128 or more keeps `out_a` high for the whole period, and a pulse width of 0 keeps it low for the whole period.
- R10: In 8-bit mode with no prescale and zero dead time, a pulse width of 128 gives `out_a` high for exactly 128 of every 256 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; both outputs are low while it is asserted |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the pulse-width holding register, 1 selects the control register |
| wr_data | input | 8 | Write data |
| out_a | output | 1 | Primary (high-side) drive |
| out_b | output | 1 | Complementary (low-side) drive |

## Verification
The bench targets the blanking window after each compare edge. A design that is off by one tick there would give the wrong on-time count, and one that switches straight across would drive both switches at once. It writes a new width partway through a period, where a design that loads the compare latch at once would produce a runt pulse. It also tries to undo the lock by writing a 7-bit, zero-dead-time, unlocked control word, which shows up as a halved period or a longer on-time. Stop is checked both while locked and while unlocked. Saturated and zero widths in 7-bit mode are checked too: a design that gets these wrong would produce a spurious edge and a dead-time gap.

// File: rtl/dtpwm_pkg.sv
// Package: shared types and control-word layout for the dead-time PWM block.
// Assumes an 8-bit control word; the bit positions below are the software map.
package dtpwm_pkg;

    localparam int DEAD_W = 4;

    localparam int CTL_STOP = 0;
    localparam int CTL_LOCK = 1;
    localparam int CTL_DIV2 = 2;
    localparam int CTL_RES7 = 3;
    localparam int CTL_DEAD = 4;

    typedef enum logic {
        SEL_WIDTH = 1'b0,
        SEL_CTRL  = 1'b1
    } dtpwm_sel_e;

    typedef struct packed {
        logic [DEAD_W-1:0] dead;
        logic              res7;
        logic              div2;
        logic              lock;
        logic              stop;
    } dtpwm_cfg_t;

endpackage

// File: rtl/dtpwm_regs.sv
// Module: register file holding the pulse-width holding value and the control word.
// Assumes the write data is at least as wide as the control layout. Once lock is
// set, only stop can still be written, and lock is cleared only by reset.
module dtpwm_regs
    import dtpwm_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output dtpwm_cfg_t        cfg,
    output logic [DATA_W-1:0] pw_hold
);

    dtpwm_cfg_t cfg_q;
    logic       ctl_wr;
    logic       wid_wr;

    // Decode which register the strobe targets.
    always_comb begin
        ctl_wr = wr_en && (dtpwm_sel_e'(wr_sel) == SEL_CTRL);
        wid_wr = wr_en && (dtpwm_sel_e'(wr_sel) == SEL_WIDTH);
    end

    // Control word update with the lock rule (R4).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (ctl_wr) begin
            cfg_q.stop <= wr_data[CTL_STOP];
            if (!cfg_q.lock) begin
                cfg_q.lock <= wr_data[CTL_LOCK];
                cfg_q.div2 <= wr_data[CTL_DIV2];
                cfg_q.res7 <= wr_data[CTL_RES7];
                cfg_q.dead <= wr_data[CTL_DEAD +: DEAD_W];
            end
        end
    end

    // Pulse-width holding register; the lock does not protect it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_hold <= '0;
        end else if (wid_wr) begin
            pw_hold <= wr_data;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/dtpwm_timebase.sv
// Module: prescaler, period counter and compare latch.
// Assumes CNT_W >= 2. Half mode wraps at 2**(CNT_W-1)-1. The compare latch loads
// from the holding register at each wrap and while stopped (R7).
module dtpwm_timebase
    import dtpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dtpwm_cfg_t       cfg,
    input  logic [CNT_W-1:0] pw_hold,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] pw_cur,
    output logic             tick
);

    localparam logic [CNT_W-1:0] TOP_FULL = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] TOP_HALF = {1'b0, {(CNT_W-1){1'b1}}};

    logic             ph;
    logic [CNT_W-1:0] top;
    logic             wrap;

    // Tick enable and the wrap point for the selected width (R5, R6).
    always_comb begin
        tick = !cfg.div2 || ph;
        top  = cfg.res7 ? TOP_HALF : TOP_FULL;
        wrap = tick && (cnt >= top);
    end

    // Prescale phase; it is held at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg.stop) begin
            ph <= 1'b0;
        end else begin
            ph <= !ph;
        end
    end

    // Period counter (R5, R8).
    always_ff @(posedge clk) begin
        if (!rst_n || cfg.stop) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Compare latch, loaded only at a period boundary or while stopped (R7).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pw_cur <= '0;
        end else if (cfg.stop || wrap) begin
            pw_cur <= pw_hold;
        end
    end

endmodule

// File: rtl/dtpwm_deadband.sv
// Module: comparator, dead-time insertion and output gating.
// Assumes the tick comes from the timebase. The blanking counter loads on every
// change of the compare result and counts down on ticks (R3).
module dtpwm_deadband
    import dtpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  dtpwm_cfg_t       cfg,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] pw_cur,
    input  logic             tick,
    output logic             out_a,
    output logic             out_b,
    output logic             dt_busy
);

    logic              cmp;
    logic              cmp_q;
    logic [DEAD_W-1:0] dt_cnt;

    // Raw comparison of the count against the latched width (R9).
    always_comb cmp = (cnt < pw_cur);

    // Registered compare result; cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg.stop) begin
            cmp_q <= 1'b0;
        end else begin
            cmp_q <= cmp;
        end
    end

    // Dead-time counter: load on each edge, count down on ticks (R3).
    always_ff @(posedge clk) begin
        if (!rst_n || cfg.stop) begin
            dt_cnt <= '0;
        end else if (cmp != cmp_q) begin
            dt_cnt <= cfg.dead;
        end else if (dt_cnt != '0 && tick) begin
            dt_cnt <= dt_cnt - 1'b1;
        end
    end

    // Output gating: complementary, with blanking, stop and reset forcing low (R2, R8).
    always_comb begin
        dt_busy = (dt_cnt != '0);
        out_a   = rst_n && !cfg.stop && !dt_busy && cmp_q;
        out_b   = rst_n && !cfg.stop && !dt_busy && !cmp_q;
    end

endmodule

// File: rtl/dtpwm_ctrl.sv
// Module: top of the complementary dead-time PWM controller.
// Assumes one clock domain and a synchronous active-low reset. Pulse width and
// control share one write port, selected by wr_sel.
module dtpwm_ctrl
    import dtpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic             out_a,
    output logic             out_b
);

    dtpwm_cfg_t       cfg;
    logic [CNT_W-1:0] pw_hold;
    logic [CNT_W-1:0] pw_cur;
    logic [CNT_W-1:0] cnt;
    logic             tick;
    logic             dt_busy;

    dtpwm_regs #(.DATA_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cfg     (cfg),
        .pw_hold (pw_hold)
    );

    dtpwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .pw_hold (pw_hold),
        .cnt     (cnt),
        .pw_cur  (pw_cur),
        .tick    (tick)
    );

    dtpwm_deadband #(.CNT_W(CNT_W)) u_db (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     (cfg),
        .cnt     (cnt),
        .pw_cur  (pw_cur),
        .tick    (tick),
        .out_a   (out_a),
        .out_b   (out_b),
        .dt_busy (dt_busy)
    );

endmodule

// File: rtl/dtpwm_ctrl_chk.sv
// Checker: temporal properties of the PWM controller, bound into the top module.
// Assumes it observes the top-level configuration, counter, tick and blanking state.
module dtpwm_ctrl_chk
    import dtpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_a,
    input logic             out_b,
    input dtpwm_cfg_t       cfg,
    input logic [CNT_W-1:0] cnt,
    input logic             tick,
    input logic             dt_busy
);

    localparam logic [CNT_W-1:0] HALF_TOP = {1'b0, {(CNT_W-1){1'b1}}};

    p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_a && out_b));

    p_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dt_busy |-> (!out_a && !out_b));

    p_lock_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg.lock) |-> cfg.lock);

    p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg.lock) |-> (cfg.dead == $past(cfg.dead) && cfg.div2 == $past(cfg.div2)
                             && cfg.res7 == $past(cfg.res7)));

    p_half_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.stop && tick && cfg.res7 && cnt == HALF_TOP) |=> (cnt == '0));

    p_no_tick_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.stop && !tick) |=> (cnt == $past(cnt)));

    p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.stop |-> (!out_a && !out_b));

    p_stop_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.stop |=> (cnt == '0));

endmodule

bind dtpwm_ctrl dtpwm_ctrl_chk #(.CNT_W(CNT_W)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .out_a   (out_a),
    .out_b   (out_b),
    .cfg     (cfg),
    .cnt     (cnt),
    .tick    (tick),
    .dt_busy (dt_busy)
);

// File: tb/test_dtpwm_ctrl.sv
// Bench: a behavioural reference model, compared with both outputs on every clock,
// plus window measurements for duty and period.
module test_dtpwm_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       out_a;
    logic       out_b;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string phase = "R1";

    // Reference model state
    int m_stop, m_lock, m_div, m_res, m_dead, m_hold, m_pw, m_ph, m_cnt, m_cq, m_dt;

    dtpwm_ctrl i_dtpwm_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .out_a   (out_a),
        .out_b   (out_b)
    );

    always #5 clk = ~clk;

    // Reference model: next state from the requirement rules
    always @(posedge clk) begin
        int tick, top, cmp, wrap;
        if (!rst_n) begin
            m_stop = 0; m_lock = 0; m_div = 0; m_res = 0; m_dead = 0;
            m_hold = 0; m_pw = 0; m_ph = 0; m_cnt = 0; m_cq = 0; m_dt = 0;
        end else begin
            tick = (!m_div || m_ph) ? 1 : 0;
            top  = m_res ? 127 : 255;
            cmp  = (m_cnt < m_pw) ? 1 : 0;
            wrap = (tick && m_cnt >= top) ? 1 : 0;
            if (m_stop) begin
                m_dt = 0; m_cq = 0; m_cnt = 0; m_ph = 0; m_pw = m_hold;
            end else begin
                if (cmp != m_cq) m_dt = m_dead;
                else if (m_dt != 0 && tick) m_dt = m_dt - 1;
                m_cq = cmp;
                if (wrap) begin
                    m_cnt = 0; m_pw = m_hold;
                end else if (tick) begin
                    m_cnt = m_cnt + 1;
                end
                m_ph = m_ph ? 0 : 1;
            end
            if (wr_en && wr_sel) begin
                m_stop = wr_data[0];
                if (!m_lock) begin
                    m_lock = wr_data[1]; m_div = wr_data[2];
                    m_res = wr_data[3]; m_dead = int'(wr_data[7:4]);
                end
            end else if (wr_en) begin
                m_hold = int'(wr_data);
            end
        end
    end

    // Per-cycle comparison against the model; also covers R2 overlap
    always @(negedge clk) begin
        logic ea, eb;
        if (rst_n && !done) begin
            ea = (!m_stop && m_dt == 0 && m_cq == 1);
            eb = (!m_stop && m_dt == 0 && m_cq == 0);
            checks++;
            if (out_a !== ea || out_b !== eb || (out_a && out_b)) begin
                errors++;
                $display("FAIL %s (model, R2): a=%0b b=%0b expected a=%0b b=%0b",
                         phase, out_a, out_b, ea, eb);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        @(negedge clk);
        wr_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_hi(input int n, output int ha, output int hb);
        ha = 0; hb = 0;
        repeat (n) begin
            @(negedge clk);
            if (out_a) ha++;
            if (out_b) hb++;
        end
    endtask

    task automatic period(output int p);
        int  first;
        bit  prev;
        first = -1; p = -1; prev = out_a;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (out_a && !prev) begin
                if (first < 0) first = i;
                else begin
                    p = i - first;
                    break;
                end
            end
            prev = out_a;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, phase %s", phase);
        finish_run();
    end

    initial begin
        int ha, hb, p;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 out_a after reset", int'(out_a), 0);
        chk("R1 out_b after reset", int'(out_b), 1);

        // R10: 50% duty at width 128
        phase = "R10";
        wr(1'b0, 8'd128);
        idle(300);
        count_hi(256, ha, hb);
        chk("R10 out_a high clocks", ha, 128);
        chk("R10 out_b high clocks", hb, 128);

        // R3: dead time 3 ticks
        phase = "R3";
        wr(1'b1, 8'h30);
        idle(300);
        count_hi(256, ha, hb);
        chk("R3 out_a high clocks", ha, 125);
        chk("R3 out_b high clocks", hb, 125);

        // R5: 7-bit mode period
        phase = "R5";
        wr(1'b1, 8'h38);
        wr(1'b0, 8'd64);
        idle(300);
        period(p);
        chk("R5 7-bit period", p, 128);

        // R9: saturated and zero widths in 7-bit mode
        phase = "R9";
        wr(1'b0, 8'd200);
        idle(300);
        count_hi(128, ha, hb);
        chk("R9 width 200 out_a high", ha, 128);
        wr(1'b0, 8'd0);
        idle(300);
        count_hi(128, ha, hb);
        chk("R9 width 0 out_a high", ha, 0);
        chk("R9 width 0 out_b high", hb, 128);

        // R6: prescale doubles the period
        phase = "R6";
        wr(1'b1, 8'h3C);
        wr(1'b0, 8'd64);
        idle(600);
        period(p);
        chk("R6 divided 7-bit period", p, 256);

        // R7: width change mid-period (checked by model every clock)
        phase = "R7";
        idle(37);
        wr(1'b0, 8'd32);
        idle(600);

        // R8: stop forces both outputs low
        phase = "R8";
        wr(1'b1, 8'h3D);
        count_hi(50, ha, hb);
        chk("R8 stop out_a", ha, 0);
        chk("R8 stop out_b", hb, 0);
        wr(1'b1, 8'h3C);
        idle(600);

        // R4: lock, then attempt to change everything
        phase = "R4";
        wr(1'b1, 8'h32);
        idle(600);
        wr(1'b1, 8'h08);
        idle(600);
        period(p);
        chk("R4 period after locked write", p, 256);
        count_hi(256, ha, hb);
        chk("R4 out_a high after locked write", ha, 29);
        wr(1'b1, 8'h03);
        count_hi(20, ha, hb);
        chk("R4 stop while locked out_a", ha, 0);
        chk("R4 stop while locked out_b", hb, 0);
        wr(1'b1, 8'h02);
        idle(300);
        period(p);
        chk("R4 period after locked restart", p, 256);

        finish_run();
    end

endmodule